// File: doc/BRIEF.md
# Programmable Sum-of-Products Logic Block

This block is the product-term core of one programmable logic block. It reads a 36-bit input vector and drives 16 sum outputs, one for each downstream register cell, plus six control outputs. Every sum output ORs five product terms that belong to it alone. On top of those, a pool of 32 shared product terms sits behind a programmable OR matrix. Any pool term can be routed to any output, and one pool term may feed several outputs at once, so a single output can collect up to 37 terms.

The six control outputs are terms over the same inputs. Each one is set individually to AND (product form) or OR (sum form) its selected literals. All term masks, OR-matrix rows and control-term forms sit in configuration registers. These registers are written one entry per clock through an address/data port and are cleared by reset. The outputs are purely combinational from the inputs and the stored configuration.

Top module: `pt_logic_block`

## Requirements
- R1: While reset is low, and after it is released, every configuration entry is empty, so `sumOut` and `ctrlOut` are all zero for any `inVec`.
- R2: A product term is the AND of its enabled literals. In a term's 72-bit mask, bit i (0..35) enables the true literal of `inVec[i]` and bit 36+i enables its complement.
- R3: A product term whose mask has no bit set evaluates to 0.
- R4: Sum output o is the OR of its five private terms, written at addresses 5*o+k (k = 0..4), together with its routed pool terms.
- R5: Pool term p is written at address 80+p. The OR-matrix row for output o is written at address 118+o, and bit p of its low 32 data bits routes pool term p to that output. A pool term that is not routed has no effect on the output.
- R6: One pool term routed in several rows drives all of those outputs. An output whose row selects all 32 pool terms responds to any of its 37 terms.
- R7: Control term c is written at address 112+c. The form register at address 134 holds one bit per control term in data bits 5..0: 1 selects sum form (OR of the enabled literals) and 0 selects product form (AND of the enabled literals).
- R8: A control term with an empty mask gives 0 in both sum and product form.
- R9: A write with `cfgWe` high to an address above 134 changes no configuration. With `cfgWe` low, no configuration changes.
- R10: Outputs follow `inVec` within the same cycle, and a configuration write shows at the outputs right after the clock edge that stores it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for configuration writes |
| rstN | input | 1 | Active-low synchronous reset; clears all configuration |
| cfgWe | input | 1 | Configuration write enable |
| cfgAddr | input | 8 | Configuration entry address |
| cfgData | input | 72 | Write data: literal mask, OR-matrix row, or form bits |
| inVec | input | 36 | Logic inputs |
| sumOut | output | 16 | Sum outputs, one per register cell |
| ctrlOut | output | 6 | Control term outputs |

## Verification
The inputs are applied as single hot bits and as small clusters, so that one private term, one routed pool term or one control literal can be told apart from its neighbours. An all-ones input and a zero input separate product behaviour from sum behaviour, and they expose any complemented literal that was wired the wrong way. A pool term routed to two outputs, with a third output left unrouted, shows that the OR matrix both shares a term and isolates it. An output with all 37 terms enabled, and an output left unconfigured, cover both ends of the term count. Rewrites at out-of-map addresses and re-programming of a live term separate ignored writes from writes that take effect at once.

// File: rtl/pt_pkg.sv
package pt_pkg;
  localparam int NUM_IN_D     = 36;
  localparam int NUM_OUT_D    = 16;
  localparam int PRIV_D       = 5;
  localparam int POOL_D       = 32;
  localparam int NUM_CTRL_D   = 6;
  localparam int CFG_ADDR_W   = 8;

  // Strobes from the address decoder to the configuration store
  typedef struct packed {
    logic                  wrPriv;
    logic                  wrPool;
    logic                  wrCtrl;
    logic                  wrRow;
    logic                  wrMode;
    logic [CFG_ADDR_W-1:0] idx;
  } cfgStrobe_t;
endpackage

// File: rtl/pt_cfg_ctrl.sv
module pt_cfg_ctrl
  import pt_pkg::*;
#(
  parameter int NUM_OUT  = NUM_OUT_D,
  parameter int PRIV     = PRIV_D,
  parameter int POOL     = POOL_D,
  parameter int NUM_CTRL = NUM_CTRL_D
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  cfgWe,
  input  logic [CFG_ADDR_W-1:0] cfgAddr,
  output cfgStrobe_t            str
);
  localparam int POOL_BASE = NUM_OUT * PRIV;
  localparam int CTRL_BASE = POOL_BASE + POOL;
  localparam int ROW_BASE  = CTRL_BASE + NUM_CTRL;
  localparam int MODE_ADDR = ROW_BASE + NUM_OUT;

  always_comb begin
    str = '0;
    if (cfgWe) begin
      if (cfgAddr < CFG_ADDR_W'(POOL_BASE)) begin
        str.wrPriv = 1'b1;
        str.idx    = cfgAddr;
      end else if (cfgAddr < CFG_ADDR_W'(CTRL_BASE)) begin
        str.wrPool = 1'b1;
        str.idx    = cfgAddr - CFG_ADDR_W'(POOL_BASE);
      end else if (cfgAddr < CFG_ADDR_W'(ROW_BASE)) begin
        str.wrCtrl = 1'b1;
        str.idx    = cfgAddr - CFG_ADDR_W'(CTRL_BASE);
      end else if (cfgAddr < CFG_ADDR_W'(MODE_ADDR)) begin
        str.wrRow  = 1'b1;
        str.idx    = cfgAddr - CFG_ADDR_W'(ROW_BASE);
      end else if (cfgAddr == CFG_ADDR_W'(MODE_ADDR)) begin
        str.wrMode = 1'b1;
      end
    end
  end

  // R9
  out_of_map_chk: assert property (@(posedge clk) disable iff (!rstN)
    (cfgWe && cfgAddr > CFG_ADDR_W'(MODE_ADDR)) |->
      !(str.wrPriv || str.wrPool || str.wrCtrl || str.wrRow || str.wrMode));
  // R9
  idle_no_strobe_chk: assert property (@(posedge clk) disable iff (!rstN)
    !cfgWe |-> !(str.wrPriv || str.wrPool || str.wrCtrl || str.wrRow || str.wrMode));
  // R5
  one_region_chk: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({str.wrPriv, str.wrPool, str.wrCtrl, str.wrRow, str.wrMode}));
endmodule

// File: rtl/pt_term.sv
module pt_term #(
  parameter int LIT_W = 72
) (
  input  logic [LIT_W-1:0] mask,
  input  logic [LIT_W-1:0] lits,
  input  logic             sumForm,
  output logic             y
);
  logic anySel;
  logic allSel;
  logic orSel;

  always_comb begin
    anySel = |mask;
    allSel = &(lits | ~mask);
    orSel  = |(lits & mask);
    y      = sumForm ? orSel : (anySel & allSel);
  end
endmodule

// File: rtl/pt_sop_array.sv
module pt_sop_array
  import pt_pkg::*;
#(
  parameter int NUM_IN   = NUM_IN_D,
  parameter int NUM_OUT  = NUM_OUT_D,
  parameter int PRIV     = PRIV_D,
  parameter int POOL     = POOL_D,
  parameter int NUM_CTRL = NUM_CTRL_D
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  cfgStrobe_t            str,
  input  logic [2*NUM_IN-1:0]   cfgData,
  input  logic [NUM_IN-1:0]     inVec,
  output logic [NUM_OUT-1:0]    sumOut,
  output logic [NUM_CTRL-1:0]   ctrlOut
);
  localparam int LIT_W      = 2 * NUM_IN;
  localparam int PRIV_TOTAL = NUM_OUT * PRIV;

  logic [LIT_W-1:0]      privMask [PRIV_TOTAL];
  logic [LIT_W-1:0]      poolMask [POOL];
  logic [LIT_W-1:0]      ctrlMask [NUM_CTRL];
  logic [POOL-1:0]       orRow    [NUM_OUT];
  logic [NUM_CTRL-1:0]   ctrlSumMode;

  logic [LIT_W-1:0]      lits;
  logic [PRIV_TOTAL-1:0] privHit;
  logic [POOL-1:0]       poolHit;

  assign lits = {~inVec, inVec};

  for (genvar g = 0; g < PRIV_TOTAL; g++) begin : gPriv
    always_ff @(posedge clk) begin
      if (!rstN) privMask[g] <= '0;
      else if (str.wrPriv && str.idx == CFG_ADDR_W'(g)) privMask[g] <= cfgData;
    end
    pt_term #(.LIT_W(LIT_W)) uTerm (
      .mask(privMask[g]), .lits(lits), .sumForm(1'b0), .y(privHit[g]));
    // R3
    empty_term_chk: assert property (@(posedge clk) disable iff (!rstN)
      (privMask[g] == '0) |-> !privHit[g]);
    // R4
    priv_reaches_out_chk: assert property (@(posedge clk) disable iff (!rstN)
      privHit[g] |-> sumOut[g / PRIV]);
  end

  for (genvar p = 0; p < POOL; p++) begin : gPool
    always_ff @(posedge clk) begin
      if (!rstN) poolMask[p] <= '0;
      else if (str.wrPool && str.idx == CFG_ADDR_W'(p)) poolMask[p] <= cfgData;
    end
    pt_term #(.LIT_W(LIT_W)) uTerm (
      .mask(poolMask[p]), .lits(lits), .sumForm(1'b0), .y(poolHit[p]));
    // R9
    pool_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
      !str.wrPool |=> $stable(poolMask[p]));
  end

  for (genvar o = 0; o < NUM_OUT; o++) begin : gOut
    always_ff @(posedge clk) begin
      if (!rstN) orRow[o] <= '0;
      else if (str.wrRow && str.idx == CFG_ADDR_W'(o)) orRow[o] <= cfgData[POOL-1:0];
    end
    assign sumOut[o] = (|privHit[o*PRIV +: PRIV]) | (|(poolHit & orRow[o]));
  end

  always_ff @(posedge clk) begin
    if (!rstN) ctrlSumMode <= '0;
    else if (str.wrMode) ctrlSumMode <= cfgData[NUM_CTRL-1:0];
  end

  for (genvar c = 0; c < NUM_CTRL; c++) begin : gCtrl
    always_ff @(posedge clk) begin
      if (!rstN) ctrlMask[c] <= '0;
      else if (str.wrCtrl && str.idx == CFG_ADDR_W'(c)) ctrlMask[c] <= cfgData;
    end
    pt_term #(.LIT_W(LIT_W)) uTerm (
      .mask(ctrlMask[c]), .lits(lits), .sumForm(ctrlSumMode[c]), .y(ctrlOut[c]));
    // R8
    empty_ctrl_chk: assert property (@(posedge clk) disable iff (!rstN)
      (ctrlMask[c] == '0) |-> !ctrlOut[c]);
  end
endmodule

// File: rtl/pt_logic_block.sv
module pt_logic_block
  import pt_pkg::*;
#(
  parameter int NUM_IN   = NUM_IN_D,
  parameter int NUM_OUT  = NUM_OUT_D,
  parameter int PRIV     = PRIV_D,
  parameter int POOL     = POOL_D,
  parameter int NUM_CTRL = NUM_CTRL_D
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  cfgWe,
  input  logic [CFG_ADDR_W-1:0] cfgAddr,
  input  logic [2*NUM_IN-1:0]   cfgData,
  input  logic [NUM_IN-1:0]     inVec,
  output logic [NUM_OUT-1:0]    sumOut,
  output logic [NUM_CTRL-1:0]   ctrlOut
);
  cfgStrobe_t str;

  pt_cfg_ctrl #(.NUM_OUT(NUM_OUT), .PRIV(PRIV), .POOL(POOL), .NUM_CTRL(NUM_CTRL)) uCtrl (
    .clk(clk), .rstN(rstN), .cfgWe(cfgWe), .cfgAddr(cfgAddr), .str(str));

  pt_sop_array #(.NUM_IN(NUM_IN), .NUM_OUT(NUM_OUT), .PRIV(PRIV), .POOL(POOL),
                 .NUM_CTRL(NUM_CTRL)) uData (
    .clk(clk), .rstN(rstN), .str(str), .cfgData(cfgData), .inVec(inVec),
    .sumOut(sumOut), .ctrlOut(ctrlOut));

  // R10
  quiet_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    ($stable(inVec) && !$past(cfgWe)) |-> ($stable(sumOut) && $stable(ctrlOut)));
endmodule

// File: tb/sim_pt_logic_block.sv
module sim_pt_logic_block;
  localparam int CLK_PERIOD = 10;
  localparam int NI = 36;
  localparam int NO = 16;
  localparam int NP = 5;
  localparam int NQ = 32;
  localparam int NC = 6;
  localparam int LW = 2 * NI;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic          cfgWe = 1'b0;
  logic [7:0]    cfgAddr = '0;
  logic [LW-1:0] cfgData = '0;
  logic [NI-1:0] inVec = '0;
  logic [NO-1:0] sumOut;
  logic [NC-1:0] ctrlOut;

  always #(CLK_PERIOD/2) clk = ~clk;

  pt_logic_block u0 (.clk(clk), .rstN(rstN), .cfgWe(cfgWe), .cfgAddr(cfgAddr),
                     .cfgData(cfgData), .inVec(inVec), .sumOut(sumOut), .ctrlOut(ctrlOut));

  // Shadow configuration built from the requirement address map
  logic [LW-1:0] sPriv [NO*NP];
  logic [LW-1:0] sPool [NQ];
  logic [LW-1:0] sCtrl [NC];
  logic [NQ-1:0] sRow  [NO];
  logic [NC-1:0] sMode;

  typedef struct {
    logic [NO-1:0] expSum;
    logic [NC-1:0] expCtrl;
    string         tag;
  } item_t;
  item_t scoreQ[$];

  int  checks = 0;
  int  failures = 0;
  bit  finished = 1'b0;

  function automatic logic termVal(logic [LW-1:0] m, logic [NI-1:0] x, bit sumForm);
    logic anyLit, allLit, orLit;
    anyLit = 1'b0; allLit = 1'b1; orLit = 1'b0;
    for (int i = 0; i < NI; i++) begin
      if (m[i])      begin anyLit = 1'b1; allLit &= x[i];  orLit |= x[i];  end
      if (m[NI + i]) begin anyLit = 1'b1; allLit &= ~x[i]; orLit |= ~x[i]; end
    end
    return sumForm ? orLit : (anyLit & allLit);
  endfunction

  function automatic logic [NO-1:0] modelSum(logic [NI-1:0] x);
    logic [NO-1:0] r;
    r = '0;
    for (int o = 0; o < NO; o++) begin
      for (int k = 0; k < NP; k++) r[o] |= termVal(sPriv[o*NP + k], x, 1'b0);
      for (int p = 0; p < NQ; p++) if (sRow[o][p]) r[o] |= termVal(sPool[p], x, 1'b0);
    end
    return r;
  endfunction

  function automatic logic [NC-1:0] modelCtrl(logic [NI-1:0] x);
    logic [NC-1:0] r;
    for (int c = 0; c < NC; c++) r[c] = termVal(sCtrl[c], x, sMode[c]);
    return r;
  endfunction

  task automatic clearShadow();
    for (int g = 0; g < NO*NP; g++) sPriv[g] = '0;
    for (int p = 0; p < NQ; p++) sPool[p] = '0;
    for (int c = 0; c < NC; c++) sCtrl[c] = '0;
    for (int o = 0; o < NO; o++) sRow[o] = '0;
    sMode = '0;
  endtask

  task automatic writeCfg(int addr, logic [LW-1:0] data);
    @(posedge clk); #1;
    cfgWe = 1'b1; cfgAddr = 8'(addr); cfgData = data;
    @(posedge clk); #1;
    cfgWe = 1'b0;
    if (addr < 80)       sPriv[addr] = data;
    else if (addr < 112) sPool[addr-80] = data;
    else if (addr < 118) sCtrl[addr-112] = data;
    else if (addr < 134) sRow[addr-118] = data[NQ-1:0];
    else if (addr == 134) sMode = data[NC-1:0];
  endtask

  // Driver: apply a pattern and push the expected result
  task automatic drive(logic [NI-1:0] x, string tag);
    item_t it;
    @(posedge clk); #1;
    inVec = x;
    it.expSum = modelSum(x);
    it.expCtrl = modelCtrl(x);
    it.tag = tag;
    scoreQ.push_back(it);
  endtask

  // Monitor: compare at the falling edge
  initial begin
    forever begin
      @(negedge clk);
      if (scoreQ.size() > 0) begin
        item_t it;
        it = scoreQ.pop_front();
        checks++;
        if (sumOut !== it.expSum || ctrlOut !== it.expCtrl) begin
          failures++;
          $display("FAIL %s: sumOut=%h ctrlOut=%h expected sumOut=%h ctrlOut=%h",
                   it.tag, sumOut, ctrlOut, it.expSum, it.expCtrl);
        end
      end
    end
  end

  initial begin
    #(CLK_PERIOD * 50000);
    if (!finished) begin
      failures++;
      $display("FAIL watchdog: run did not complete, actual hung expected done");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, failures);
      $finish;
    end
  end

  initial begin
    logic [LW-1:0] d;
    clearShadow();
    inVec = '1;
    repeat (3) @(posedge clk);
    #1 rstN = 1'b1;

    drive('1, "R1 reset all ones");
    drive(36'h0, "R1 reset zeros");

    // R2: out0 term0 = x0 & ~x1
    d = '0; d[0] = 1'b1; d[NI+1] = 1'b1;
    writeCfg(0, d);
    drive(36'h1, "R2 x0 set x1 clear");
    drive(36'h3, "R2 complement literal blocks");
    drive(36'h0, "R3 empty terms give 0");

    // R4: out3 private terms on x4..x8
    for (int k = 0; k < NP; k++) begin
      d = '0; d[4+k] = 1'b1;
      writeCfg(15 + k, d);
    end
    drive(36'h40, "R4 out3 via third private term");
    drive(36'h100, "R4 out3 via fifth private term");

    // R5/R6: pool0 = x10 & x11, shared by out5 and out6, not out7
    d = '0; d[10] = 1'b1; d[11] = 1'b1;
    writeCfg(80, d);
    for (int p = 1; p < NQ; p++) begin
      d = '0; d[p] = 1'b1;
      writeCfg(80 + p, d);
    end
    drive(36'hC00, "R5 pool term unrouted before rows");
    writeCfg(118 + 5, 72'h1);
    writeCfg(118 + 6, 72'h1);
    drive(36'hC00, "R6 shared pool term on out5 and out6");
    drive(36'h400, "R5 partial pool term stays low");

    // R6: out9 uses all 37 terms
    for (int k = 0; k < NP; k++) begin
      d = '0; d[20+k] = 1'b1;
      writeCfg(45 + k, d);
    end
    writeCfg(118 + 9, {40'h0, 32'hFFFF_FFFF});
    drive(36'h8000_0000, "R6 out9 via pool term 31");
    drive(36'h0040_0000, "R6 out9 via private and pool");

    // R7/R8: control terms
    d = '0; d[0] = 1'b1; d[2] = 1'b1;
    writeCfg(112, d);
    writeCfg(113, d);
    d = '0; d[NI+3] = 1'b1;
    writeCfg(116, d);
    d = '0; d[0] = 1'b1; d[NI+3] = 1'b1;
    writeCfg(117, d);
    writeCfg(134, 72'h26);
    drive(36'h5, "R7 product and sum both high");
    drive(36'h1, "R7 sum high product low");
    drive(36'h0, "R8 empty control terms low");
    drive(36'h8, "R7 complement literal sum form");
    drive('1, "R7 all ones pattern");

    // R9: out-of-map writes ignored
    writeCfg(135, '1);
    writeCfg(200, '1);
    drive(36'h0, "R9 out-of-map writes ignored zeros");
    drive(36'h3, "R9 out-of-map writes ignored pattern");

    // R10: live rewrite of a term visible at once
    drive(36'h1, "R10 before rewrite");
    writeCfg(0, '0);
    drive(36'h1, "R10 after rewrite term empty");
    writeCfg(118 + 5, 72'h0);
    drive(36'hC00, "R10 row cleared out5 drops");

    repeat (3) @(posedge clk);
    finished = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, failures);
    $finish;
  end
endmodule